// File: doc/BRIEF.md
# Guest-Stage Implicit Access Checker

This block judges one implicit memory access made by a guest page-table walker against the second-stage (guest-physical to host-physical) leaf entry that covers it. The walker makes two kinds of implicit access. It reads a guest page-table entry, and it may write back the accessed and dirty bits into that entry. For each request the block returns a verdict: the access is allowed, it causes a load guest page fault, or it causes a store guest page fault. It also returns a flag that says whether the hardware write-back of the accessed and dirty bits should go ahead.

The walker presents the 64-bit second-stage leaf entry, the access kind and the two hardware accessed/dirty update enables for one cycle with `req_valid`. The block has two named states. `ST_IDLE` waits for a request. `ST_REPORT` holds for the single cycle after a request, and `done` is high in that cycle. Two transitions are named. `T_ACCEPT` goes to `ST_REPORT` whenever `req_valid` is high, from either state. `T_RETIRE` goes from `ST_REPORT` back to `ST_IDLE` when no new request arrives. Between requests the verdict and the write-back flag keep their last values. Bits 63 to 8 of the entry (the frame number and reserved bits) and the X, G, A and D bits have no effect on the result.

Top module: `gchk_top`

## Requirements
- R1: After reset, `done` is 0, `verdict` is 2'b00 (allow) and `ad_wb_ok` is 0.
- R2: `done` is 1 in exactly the cycle after each cycle in which `req_valid` is 1, including back-to-back requests, and is 0 in every other cycle.
- R3: A read request (`req_kind`=0) whose entry has the valid bit (bit 0) clear gives `verdict`=2'b01 (load guest page fault).
- R4: A read request whose entry has the valid, read (bit 1) and user (bit 4) bits set gives `verdict`=2'b00, whatever the write bit (bit 2) holds.
- R5: A write-back request (`req_kind`=1) with both enables set, whose entry has valid, read and user set but write clear, gives `verdict`=2'b10 (store guest page fault).
- R6: A write-back request with both enables set, whose entry has valid, read, write and user set, gives `verdict`=2'b00 and `ad_wb_ok`=1.
- R7: A write-back request with `menv_hwad` or `henv_hwad` clear gives `verdict`=2'b00 and `ad_wb_ok`=0, whatever the entry holds.
- R8: An entry with the user bit clear faults: a read gives 2'b01, and a write-back with both enables set gives 2'b10.
- R9: An entry with write set and read clear is treated as invalid: a read gives 2'b01, and a write-back with both enables set gives 2'b10.
- R10: A read request whose entry has valid and user set but read clear (execute-only, or a non-leaf pointer) gives 2'b01.
- R11: In cycles after a cycle with `req_valid`=0, `verdict` and `ad_wb_ok` keep their previous values.
- R12: `ad_wb_ok` is 1 only after a write-back request, and only together with `verdict`=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_kind | input | 1 | 0 = implicit entry read, 1 = accessed/dirty write-back |
| g_pte | input | 64 | Second-stage leaf entry: V=0, R=1, W=2, X=3, U=4, A=6, D=7 |
| menv_hwad | input | 1 | Machine-level hardware A/D update enable |
| henv_hwad | input | 1 | Hypervisor-level hardware A/D update enable |
| done | output | 1 | High for the one cycle after a request |
| verdict | output | 2 | 00 allow, 01 load guest page fault, 10 store guest page fault |
| ad_wb_ok | output | 1 | The A/D write-back may be performed |

## Verification
The bench targets the entries that are readable but not writable. A checker that tests only the valid bit would let a write-back through on such an entry, when it must report a store fault. It also covers write-back requests with only one of the two enables set. A design that ORs the enables would then report a fault or grant a write-back where it should simply allow with no write. The reserved write-without-read encoding, entries with the user bit clear and execute-only entries are each applied to both kinds of access, so a check that is missing or applied to the wrong kind shows up as the wrong fault code. Back-to-back strobes and long idle gaps catch a `done` that sticks high or a verdict that drifts between requests.

// File: rtl/gchk_pkg.sv
package gchk_pkg;
    localparam int PTE_BITS = 64;
    localparam int BIT_V = 0;
    localparam int BIT_R = 1;
    localparam int BIT_W = 2;
    localparam int BIT_X = 3;
    localparam int BIT_U = 4;
    localparam int BIT_A = 6;
    localparam int BIT_D = 7;

    typedef enum logic {
        KIND_READ = 1'b0,
        KIND_ADWB = 1'b1
    } acc_kind_t;

    typedef enum logic [1:0] {
        VD_ALLOW = 2'b00,
        VD_LOAD  = 2'b01,
        VD_STORE = 2'b10
    } verdict_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } chk_state_t;
endpackage

// File: rtl/gchk_perm.sv
module gchk_perm
    import gchk_pkg::*;
#(
    parameter int W = PTE_BITS
) (
    input  logic [W-1:0] pte,
    output logic         rd_ok,
    output logic         wr_ok
);
    logic vld, rd, wr, usr, lawful;

    always_comb begin
        vld    = pte[BIT_V];
        rd     = pte[BIT_R];
        wr     = pte[BIT_W];
        usr    = pte[BIT_U];
        // write without read is a reserved encoding
        lawful = vld & usr & ~(wr & ~rd);
        rd_ok  = lawful & rd;
        wr_ok  = lawful & rd & wr;
    end

    // R9
    always_comb begin
        reserved_enc_chk: assert (!(pte[BIT_W] && !pte[BIT_R]) || (!rd_ok && !wr_ok));
    end
endmodule

// File: rtl/gchk_adgate.sv
module gchk_adgate #(
    parameter int N_LEVELS = 2
) (
    input  logic [N_LEVELS-1:0] en_bits,
    output logic                hw_ad_on
);
    // hardware A/D updating needs every privilege level to agree
    assign hw_ad_on = &en_bits;
endmodule

// File: rtl/gchk_top.sv
module gchk_top
    import gchk_pkg::*;
#(
    parameter int W = PTE_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic         req_kind,
    input  logic [W-1:0] g_pte,
    input  logic         menv_hwad,
    input  logic         henv_hwad,
    output logic         done,
    output logic [1:0]   verdict,
    output logic         ad_wb_ok
);
    localparam int N_EN = 2;

    chk_state_t state_q, state_d;
    verdict_t   vd_q, vd_d;
    logic       ad_q, ad_d;
    logic       rd_ok, wr_ok, hw_ad_on;
    acc_kind_t  kind;

    assign kind = acc_kind_t'(req_kind);

    gchk_perm #(.W(W)) u_perm (
        .pte   (g_pte),
        .rd_ok (rd_ok),
        .wr_ok (wr_ok)
    );

    gchk_adgate #(.N_LEVELS(N_EN)) u_adgate (
        .en_bits  ({menv_hwad, henv_hwad}),
        .hw_ad_on (hw_ad_on)
    );

    // next state: T_ACCEPT on any strobe, T_RETIRE otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = req_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // verdict for the request presented this cycle
    always_comb begin
        vd_d = vd_q;
        ad_d = ad_q;
        if (req_valid) begin
            unique case (kind)
                KIND_READ: begin
                    vd_d = rd_ok ? VD_ALLOW : VD_LOAD;
                    ad_d = 1'b0;
                end
                KIND_ADWB: begin
                    if (!hw_ad_on) begin
                        vd_d = VD_ALLOW;
                        ad_d = 1'b0;
                    end else begin
                        vd_d = wr_ok ? VD_ALLOW : VD_STORE;
                        ad_d = wr_ok;
                    end
                end
                default: begin
                    vd_d = VD_ALLOW;
                    ad_d = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vd_q <= VD_ALLOW;
            ad_q <= 1'b0;
        end else begin
            vd_q <= vd_d;
            ad_q <= ad_d;
        end
    end

    assign done     = (state_q == ST_REPORT);
    assign verdict  = vd_q;
    assign ad_wb_ok = ad_q;

    // R2
    done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);
    // R2
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !done);
    // R3
    load_fault_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_kind && !g_pte[BIT_V]) |=> (verdict == 2'b01));
    // R5
    store_fault_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind && menv_hwad && henv_hwad && g_pte[BIT_R] && !g_pte[BIT_W])
        |=> (verdict == 2'b10));
    // R7
    no_wb_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind && !(menv_hwad && henv_hwad)) |=> (verdict == 2'b00 && !ad_wb_ok));
    // R11
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(verdict) && $stable(ad_wb_ok)));
    // R12
    wb_only_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_wb_ok |-> (verdict == 2'b00));
endmodule

// File: tb/sim_gchk_top.sv
`timescale 1ns/1ps
module sim_gchk_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_kind = 1'b0;
    logic [63:0] g_pte = '0;
    logic        menv_hwad = 1'b0;
    logic        henv_hwad = 1'b0;
    logic        done;
    logic [1:0]  verdict;
    logic        ad_wb_ok;

    int errors = 0;
    int checks = 0;
    string cur_tag = "R1";
    bit finished = 1'b0;

    // reference model state
    bit       m_done = 1'b0;
    bit [1:0] m_vd = 2'b00;
    bit       m_ad = 1'b0;

    always #2 clk = ~clk;

    gchk_top u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .g_pte(g_pte), .menv_hwad(menv_hwad), .henv_hwad(henv_hwad),
        .done(done), .verdict(verdict), .ad_wb_ok(ad_wb_ok)
    );

    function automatic bit [2:0] model(bit k, bit [63:0] p, bit me, bit he);
        bit v = p[0], r = p[1], w = p[2], u = p[4];
        if (k == 1'b0) begin
            if (v && r && u && !(w && !r)) return {2'b00, 1'b0};
            return {2'b01, 1'b0};
        end
        if (!(me && he)) return {2'b00, 1'b0};
        if (v && r && w && u) return {2'b00, 1'b1};
        return {2'b10, 1'b0};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_done <= 1'b0; m_vd <= 2'b00; m_ad <= 1'b0;
        end else begin
            m_done <= req_valid;
            if (req_valid) {m_vd, m_ad} <= model(req_kind, g_pte, menv_hwad, henv_hwad);
        end
    end

    // compare every clock, away from the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            checks++;
            if (done !== m_done) begin
                errors++;
                $display("FAIL R2 done actual=%0b expected=%0b", done, m_done);
            end
            checks++;
            if (verdict !== m_vd || ad_wb_ok !== m_ad) begin
                errors++;
                $display("FAIL %s verdict/ad actual=%0b/%0b expected=%0b/%0b",
                         cur_tag, verdict, ad_wb_ok, m_vd, m_ad);
            end
        end
    end

    task automatic send(string tag, bit k, bit [63:0] p, bit me, bit he, bit keep);
        @(negedge clk);
        cur_tag = tag;
        req_valid = 1'b1; req_kind = k; g_pte = p; menv_hwad = me; henv_hwad = he;
        if (!keep) begin
            @(negedge clk);
            req_valid = 1'b0;
            g_pte = 64'hFFFF_FFFF_FFFF_FF00;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit [63:0] ppn;
        ppn = 64'h0000_0000_2000_0000;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (done !== 1'b0 || verdict !== 2'b00 || ad_wb_ok !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset actual=%0b/%0b/%0b expected=0/00/0", done, verdict, ad_wb_ok);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        send("R3", 1'b0, ppn | 64'h1E, 1'b1, 1'b1, 1'b0);
        send("R4", 1'b0, ppn | 64'h13, 1'b0, 1'b0, 1'b0);
        send("R4", 1'b0, ppn | 64'hDF, 1'b1, 1'b1, 1'b0);
        send("R5", 1'b1, ppn | 64'h1B, 1'b1, 1'b1, 1'b0);
        send("R6", 1'b1, ppn | 64'hD7, 1'b1, 1'b1, 1'b0);
        repeat (4) @(negedge clk);            // R11 idle hold
        send("R7", 1'b1, ppn | 64'h1B, 1'b1, 1'b0, 1'b0);
        send("R7", 1'b1, 64'h0, 1'b0, 1'b1, 1'b0);
        send("R7", 1'b1, ppn | 64'h17, 1'b0, 1'b0, 1'b0);
        send("R8", 1'b0, ppn | 64'h0F, 1'b1, 1'b1, 1'b0);
        send("R8", 1'b1, ppn | 64'h07, 1'b1, 1'b1, 1'b0);
        send("R9", 1'b0, ppn | 64'h15, 1'b1, 1'b1, 1'b0);
        send("R9", 1'b1, ppn | 64'h15, 1'b1, 1'b1, 1'b0);
        send("R10", 1'b0, ppn | 64'h19, 1'b0, 1'b0, 1'b0);
        send("R10", 1'b0, ppn | 64'h11, 1'b0, 1'b0, 1'b0);
        // R2 / R12: back-to-back strobes of mixed kinds
        send("R12", 1'b1, ppn | 64'h17, 1'b1, 1'b1, 1'b1);
        send("R12", 1'b0, ppn | 64'h17, 1'b1, 1'b1, 1'b1);
        send("R2",  1'b1, ppn | 64'h13, 1'b1, 1'b1, 1'b1);
        send("R2",  1'b1, ppn | 64'h17, 1'b1, 1'b1, 1'b0);
        cur_tag = "R11";
        repeat (6) @(negedge clk);
        for (int i = 0; i < 64; i++) begin
            send("R4", i[0], ppn | 64'(i * 5 % 256), i[1], i[2] | i[3], i[4]);
        end
        @(negedge clk);
        req_valid = 1'b0;
        cur_tag = "R11";
        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule